// File: doc/BRIEF.md
# 64-bit Event Timer with Register Port

A programmable up-counter with a 64-bit count and a 64-bit compare period, reached through a single-cycle 32-bit register port (byte address, write strobe, write data, combinational read data). Each 64-bit quantity is split into a low word (bits 31:0) and a high word (bits 63:32) at adjacent offsets. Software programs the period, clears or presets the counter, and then starts the timer in one-shot or periodic mode.

A global control register must release the timer from reset (both release bits set) before it counts. When the running count equals the period, a sticky status flag is set and, if the interrupt is enabled, a one-cycle interrupt pulse is raised. In periodic mode the counter restarts from zero. In one-shot mode it stops and hardware returns the mode field to off.

Top module: `tmr64_event_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Counter low/high words sit at offsets 0x10/0x14 and period low/high at 0x18/0x1C; the low word is bits [31:0], the high word bits [63:32], and a carry out of the low word reaches the high word.
- R3: While global control (offset 0x24) bits [1:0] are not both 1, the counter reads zero, ignores writes and does not count.
- R4: When released and the mode field (offset 0x20, bits [7:6]) is 01 or 10, the counter increases by one every clock until it equals the period.
- R5: In periodic mode (10), on a count equal to the period the counter becomes zero on the next clock and keeps running, giving one match every period+1 clocks.
- R6: In one-shot mode (01), on a match the counter stops at the period value and the mode field reads back 00.
- R7: `irq_o` is a one-clock pulse in the clock after a match when bit 0 of offset 0x44 is 1, and stays low when that bit is 0.
- R8: Bit 1 of offset 0x44 is set by every match regardless of the enable bit; writing 1 to it clears it and writing 0 leaves it.
- R9: Mode 00 and reserved mode 11 both hold the counter; the counter words are writable while held in this way.
- R10: Unmapped offsets read zero, and offset 0x20 reads back only bits [7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt pulse on period match |

## Verification
Register traffic is driven from a vector table while the timer is held in reset, separating true storage (period words, control fields) from held state (counter words reading zero) and from unmapped space. Periodic runs with a short period distinguish an off-by-one in the match interval from a wrong wrap value, while one-shot runs with the interrupt disabled tell the sticky status apart from the interrupt pulse. A preset just below the 32-bit boundary shows whether the carry reaches the high word, and the reserved mode and a mid-run reset release show that counting truly stops.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_PRD_LO = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PRD_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_GCTL   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_ICS    = 8'h44;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_LOOP = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rel_i,
  input  logic             run_i,
  input  logic             loop_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign match_o = run_i && (cnt_q == prd_i);
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!rel_i) begin
      cnt_d = '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_d[DATA_W-1:0]     = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:DATA_W] = wdata_i;
    end else if (match_o) begin
      if (loop_i) cnt_d = '0;   // one-shot holds at the match value
    end else if (run_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  p_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i && run_i && !match_o && !wr_lo_i && !wr_hi_i |=> cnt_o == $past(cnt_o) + 1'b1);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> cnt_o == '0);
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i && match_o && loop_i && !wr_lo_i && !wr_hi_i |=> cnt_o == '0);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i && !run_i && !wr_lo_i && !wr_hi_i |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic ien_i,
  input  logic clr_i,
  output logic status_o,
  output logic irq_o
);
  logic status_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= match_i && ien_i;
      if (match_i)    status_q <= 1'b1;   // a new match wins over a clear
      else if (clr_i) status_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  p_irq_sets_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o);
  p_irq_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |=> !irq_o);
  p_status_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> status_o);
  p_status_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o && !clr_i |=> status_o);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              match_i,
  input  logic              status_i,
  output logic [CNT_W-1:0]  prd_o,
  output logic              rel_o,
  output logic              run_o,
  output logic              loop_o,
  output logic              cnt_wr_lo_o,
  output logic              cnt_wr_hi_o,
  output logic              ien_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0] prd_q;
  mode_e            mode_q;
  logic [1:0]       gctl_q;
  logic             ien_q;
  logic             wr_ctrl;

  assign wr_ctrl     = we_i && (addr_i == OFS_CTRL);
  assign cnt_wr_lo_o = we_i && (addr_i == OFS_CNT_LO);
  assign cnt_wr_hi_o = we_i && (addr_i == OFS_CNT_HI);
  assign clr_o       = we_i && (addr_i == OFS_ICS) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q  <= '0;
      mode_q <= MODE_OFF;
      gctl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (we_i && addr_i == OFS_PRD_LO) prd_q[DATA_W-1:0]     <= wdata_i;
      if (we_i && addr_i == OFS_PRD_HI) prd_q[CNT_W-1:DATA_W] <= wdata_i;
      if (we_i && addr_i == OFS_GCTL)   gctl_q <= wdata_i[1:0];
      if (we_i && addr_i == OFS_ICS)    ien_q  <= wdata_i[0];
      if (wr_ctrl)                              mode_q <= mode_e'(wdata_i[7:6]);
      else if (match_i && mode_q == MODE_ONCE)  mode_q <= MODE_OFF;
    end
  end

  assign prd_o  = prd_q;
  assign rel_o  = &gctl_q;
  assign run_o  = rel_o && (mode_q == MODE_ONCE || mode_q == MODE_LOOP);
  assign loop_o = (mode_q == MODE_LOOP);
  assign ien_o  = ien_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
      OFS_CNT_HI: rdata_o = cnt_i[CNT_W-1:DATA_W];
      OFS_PRD_LO: rdata_o = prd_q[DATA_W-1:0];
      OFS_PRD_HI: rdata_o = prd_q[CNT_W-1:DATA_W];
      OFS_CTRL:   rdata_o[7:6] = mode_q;
      OFS_GCTL:   rdata_o[1:0] = gctl_q;
      OFS_ICS:    rdata_o[1:0] = {status_i, ien_q};
      default:    rdata_o = '0;
    endcase
  end

  p_once_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && mode_q == MODE_ONCE && !wr_ctrl |=> mode_q == MODE_OFF);
  p_match_needs_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |-> rel_o);
endmodule

// File: rtl/tmr64_event_timer.sv
module tmr64_event_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt, prd;
  logic rel, run, loop, wr_lo, wr_hi, ien, clr, match, status;

  tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .cnt_i(cnt), .match_i(match), .status_i(status),
    .prd_o(prd), .rel_o(rel), .run_o(run), .loop_o(loop),
    .cnt_wr_lo_o(wr_lo), .cnt_wr_hi_o(wr_hi), .ien_o(ien), .clr_o(clr),
    .rdata_o
  );

  tmr_count #(.DATA_W(DATA_W)) u_count (
    .clk_i, .rst_ni, .rel_i(rel), .run_i(run), .loop_i(loop),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i, .prd_i(prd),
    .cnt_o(cnt), .match_o(match)
  );

  tmr_irq u_irq (
    .clk_i, .rst_ni, .match_i(match), .ien_i(ien), .clr_i(clr),
    .status_o(status), .irq_o
  );

  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !$past(match) |-> 1'b0);
endmodule

// File: tb/tb_tmr64_event_timer.sv
`timescale 1ns/1ps
module tb_tmr64_event_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  tmr64_event_timer dut (.clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o, .irq_o);

  // {addr, write data, expected read-back}, timer held (global control = 0)
  localparam int NV = 11;
  localparam logic [71:0] VEC [NV] = '{
    {8'h18, 32'hDEADBEEF, 32'hDEADBEEF},  // R2
    {8'h1C, 32'h01234567, 32'h01234567},  // R2
    {8'h10, 32'h00000055, 32'h00000000},  // R3 held
    {8'h14, 32'h00000066, 32'h00000000},  // R3 held
    {8'h20, 32'hFFFFFFFF, 32'h000000C0},  // R10
    {8'h20, 32'h00000040, 32'h00000040},  // R10
    {8'h20, 32'h00000000, 32'h00000000},  // R10
    {8'h30, 32'h00001234, 32'h00000000},  // R10 unmapped
    {8'h44, 32'h00000001, 32'h00000001},  // R8 enable bit
    {8'h44, 32'h00000000, 32'h00000000},  // R8
    {8'h24, 32'h00000003, 32'h00000003}   // R3 release
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5 d = rdata_o;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int irq_seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][71:64], v);
      check("R1", v, 32'h0);
    end
    rd(8'h44, v);
    check("R1", v, 32'h0);
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check($sformatf("R2/R3/R8/R10 vec%0d", i), v, VEC[i][31:0]);
    end

    // R9 counter writable while disabled, released
    wr(8'h10, 32'h77); wr(8'h14, 32'h9);
    rd(8'h10, v); check("R9 cnt lo", v, 32'h77);
    rd(8'h14, v); check("R9 cnt hi", v, 32'h9);
    wait_cyc(4);
    rd(8'h10, v); check("R9 hold", v, 32'h77);

    // R5/R7 periodic, period 3, interrupt enabled
    wr(8'h10, 0); wr(8'h14, 0); wr(8'h18, 3); wr(8'h1C, 0);
    wr(8'h44, 32'h1);
    wr(8'h20, 32'h80);
    addr_i = 8'h10;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_i);
      #0.5;
      check($sformatf("R5/R7 irq k=%0d", k), {31'h0, irq_o}, {31'h0, (k % 4) == 0});
      if (k == 2) check("R4 count", rdata_o, 32'h2);
      if (k == 4) check("R5 wrap", rdata_o, 32'h0);
    end
    wr(8'h20, 32'h0);
    rd(8'h44, v); check("R8 status set", v, 32'h3);
    wr(8'h44, 32'h1);
    rd(8'h44, v); check("R8 write 0 keeps", v, 32'h3);
    wr(8'h44, 32'h3);
    rd(8'h44, v); check("R8 w1c", v, 32'h1);

    // R9 reserved mode holds
    rd(8'h10, v);
    wr(8'h20, 32'hC0);
    wait_cyc(5);
    rd(8'h10, v2); check("R9 reserved", v2, v);

    // R6 one-shot with interrupt disabled
    wr(8'h20, 0); wr(8'h44, 32'h2);
    wr(8'h10, 0); wr(8'h18, 2);
    wr(8'h20, 32'h40);
    irq_seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (irq_o) irq_seen++;
    end
    check("R7 masked", irq_seen, 0);
    rd(8'h10, v); check("R6 stop", v, 32'h2);
    rd(8'h20, v); check("R6 mode off", v, 32'h0);
    rd(8'h44, v); check("R8 status no enable", v, 32'h2);

    // R2 carry into high word
    wr(8'h18, 0); wr(8'h1C, 1);
    wr(8'h10, 32'hFFFFFFFE); wr(8'h14, 0);
    wr(8'h20, 32'h80);
    wait_cyc(2);
    rd(8'h10, v); check("R2 carry lo", v, 32'h0);
    rd(8'h14, v); check("R2 carry hi", v, 32'h1);

    // R3 reset hold mid-run
    wr(8'h24, 32'h1);
    rd(8'h14, v); check("R3 hi cleared", v, 32'h0);
    wait_cyc(3);
    rd(8'h10, v); check("R3 no count", v, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule